// File: doc/BRIEF.md
# Majority Coincidence Trigger Unit

This block merges four per-channel self-trigger signals into one common acquisition trigger for the whole board. A 32-bit configuration word picks three settings. The first is which channels may take part. The second is how long a coincidence window each accepted self-trigger opens. The third is a majority threshold.

When the threshold is zero, the block acts as a plain OR of the enabled channels' rising edges, and the window setting has no effect. When the threshold is nonzero, each enabled channel stays "active" for a stretch of clock cycles after its rising edge. A trigger is produced when the number of active channels is strictly greater than the threshold. For example, with all four channels enabled and a threshold of 1, any two channels whose windows overlap cause a trigger.

The trigger output is a registered one-cycle pulse, and it fires only on the cycle where the condition becomes true. The self-trigger inputs are assumed to be synchronous to the clock. The configuration word is sampled on every clock, so a new setting applies one cycle after it is driven. Software is expected to keep the threshold below the number of enabled channels; otherwise no trigger can ever occur.

Top module: `coinc_trigger`

## Requirements
- R1: While reset is held, and in the first cycle after it, `trig_out` is 0. Reset also clears every channel's window, so an edge seen before reset cannot pair with an edge seen after it.
- R2: Configuration bits [3:0] form the channel enable mask, with bit i belonging to `self_trig[i]`. A channel whose bit is 0 never contributes to `trig_out`.
- R3: Configuration bits [26:24] hold the majority threshold L. When L is nonzero, a set of simultaneous enabled edges causes a trigger exactly when its size is greater than L.
- R4: Configuration bits [23:20] hold the window length W, counted in clock cycles. When L is nonzero, a channel is active in the cycle its edge is registered and for the W cycles that follow. Two enabled edges d cycles apart therefore coincide exactly when d <= W. This also covers W = 0, where only edges in the same cycle coincide.
- R5: When L is 0, every enabled rising edge that is isolated in time gives one trigger pulse, and W has no effect.
- R6: `trig_out` is high for exactly one cycle. It goes high two clock edges after the edge that completes the condition is first sampled. It does not fire again until the active count has fallen to L or below.
- R7: A new rising edge on a channel that is already active restarts that channel's window at its full length W.
- R8: Only rising edges count. An input that stays high for many cycles counts as a single event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Trigger clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 32 | Configuration: mask [3:0], window [23:20], threshold [26:24] |
| self_trig | input | 4 | Per-channel self-trigger levels, synchronous to `clk` |
| trig_out | output | 1 | Common trigger, one-cycle pulse |

## Verification
The bound checker monitors four properties on every cycle. The trigger pulse never lasts longer than one cycle. An all-zero mask keeps the output low. Each window counter reloads to W on a registered edge and otherwise counts down by exactly one. A registered edge flag is only ever set by a channel that was actually high.

The remaining behaviour can only be shown by the bench's scenarios. These cover the strict greater-than comparison, the d <= W coincidence boundary, window reload on a retrigger, the OR fallback at threshold zero, and the clearing of windows by reset. The bench sweeps every mask, every threshold from 0 to 3 and every edge subset, and it also sweeps a grid of window lengths against edge spacings.

// File: rtl/coinc_trigger.sv
module coinc_trigger #(
  parameter int NCH      = 4,
  parameter int WIN_W    = 4,
  parameter int LVL_W    = 3,
  parameter int CFG_W    = 32,
  parameter int MASK_LSB = 0,
  parameter int WIN_LSB  = 20,
  parameter int LVL_LSB  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [NCH-1:0]   self_trig,
  output logic             trig_out
);
  localparam int CNT_W = $clog2(NCH + 1);

  logic [CFG_W-1:0]          cfg_q;
  logic [NCH-1:0]            prev_q;
  logic [NCH-1:0]            edge_q;
  logic [NCH-1:0][WIN_W-1:0] cnt;
  logic [NCH-1:0]            act;
  logic [CNT_W-1:0]          nact;
  logic                      over, over_q;

  wire [NCH-1:0]   en  = cfg_q[MASK_LSB +: NCH];
  wire [WIN_W-1:0] win = cfg_q[WIN_LSB +: WIN_W];
  wire [LVL_W-1:0] lvl = cfg_q[LVL_LSB +: LVL_W];
  wire             coinc_mode = (lvl != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      cfg_q  <= cfg_word;
      prev_q <= self_trig;
      edge_q <= self_trig & ~prev_q & en;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt[i] <= '0;
      else if (edge_q[i])        cnt[i] <= win;
      else if (cnt[i] != '0)     cnt[i] <= cnt[i] - 1'b1;
    end
    assign act[i] = en[i] & (edge_q[i] | (coinc_mode & (cnt[i] != '0)));
  end

  always_comb begin
    nact = '0;
    for (int i = 0; i < NCH; i++) nact = nact + CNT_W'(act[i]);
  end

  assign over = (32'(nact) > 32'(lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q   <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      over_q   <= over;
      trig_out <= over & ~over_q;
    end
  end
endmodule

module coinc_trigger_chk #(
  parameter int NCH      = 4,
  parameter int WIN_W    = 4,
  parameter int CFG_W    = 32,
  parameter int MASK_LSB = 0,
  parameter int WIN_LSB  = 20
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      trig_out,
  input logic [NCH-1:0]            self_trig,
  input logic [CFG_W-1:0]          cfg_q,
  input logic [NCH-1:0]            edge_q,
  input logic [NCH-1:0][WIN_W-1:0] cnt
);
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

  p_mask_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[MASK_LSB +: NCH] == '0) |=> !trig_out);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q[i] |=> (cnt[i] == $past(cfg_q[WIN_LSB +: WIN_W])));

    p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_q[i] && cnt[i] != '0) |=> (cnt[i] == $past(cnt[i]) - 1'b1));

    p_edge_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_q[i]) |-> $past(self_trig[i]));
  end
endmodule

bind coinc_trigger coinc_trigger_chk #(
  .NCH(NCH), .WIN_W(WIN_W), .CFG_W(CFG_W), .MASK_LSB(MASK_LSB), .WIN_LSB(WIN_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .self_trig(self_trig),
  .cfg_q(cfg_q), .edge_q(edge_q), .cnt(cnt)
);

// File: tb/sim_coinc_trigger.sv
module sim_coinc_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [3:0]  self_trig = '0;
  logic        trig_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [3:0] seq [0:23];

  coinc_trigger u0 (.clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
                    .self_trig(self_trig), .trig_out(trig_out));

  always #5 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 200000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input int mask, input int win, input int lvl);
    return 32'(mask & 15) | (32'(win & 15) << 20) | (32'(lvl & 7) << 24);
  endfunction

  function automatic int pop4(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  task automatic clear_seq();
    for (int i = 0; i < 24; i++) seq[i] = '0;
  endtask

  // Drive seq one cycle at a time and record the trigger pulses seen.
  task automatic play(input logic [31:0] cfg, output int np, output int fi);
    @(negedge clk);
    cfg_word = cfg;
    np = 0;
    fi = -1;
    for (int i = 0; i < 44; i++) begin
      @(negedge clk);
      if (trig_out) begin
        if (fi < 0) fi = i;
        np++;
      end
      self_trig = (i < 24) ? seq[i] : 4'h0;
    end
  endtask

  task automatic expect_pulses(input string req, input int np, input int fi,
                               input int exp_np, input int exp_fi);
    check(np == exp_np, req, np, exp_np);
    if (exp_np > 0) check(fi == exp_fi, req, fi, exp_fi);
  endtask

  initial begin
    int np, fi;
    repeat (3) @(negedge clk);
    check(trig_out == 1'b0, "R1 during reset", int'(trig_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig_out == 1'b0, "R1 after reset", int'(trig_out), 0);

    // R2/R3/R6: every mask, threshold and subset of simultaneous edges
    for (int m = 0; m < 16; m++)
      for (int l = 0; l < 4; l++)
        for (int s = 1; s < 16; s++) begin
          int hit;
          clear_seq();
          seq[2] = 4'(s);
          hit = (pop4(4'(s & m)) > l) ? 1 : 0;
          play(mkcfg(m, 3, l), np, fi);
          expect_pulses($sformatf("R2 R3 R6 mask=%0d lvl=%0d sub=%0d", m, l, s),
                        np, fi, hit, 4);
        end

    // R4: spacing against window length, threshold 1
    for (int w = 0; w < 7; w++)
      for (int d = 0; d < 8; d++) begin
        clear_seq();
        seq[2] = 4'h1;
        seq[2 + d] = seq[2 + d] | 4'h2;
        play(mkcfg(15, w, 1), np, fi);
        expect_pulses($sformatf("R4 W=%0d d=%0d", w, d), np, fi,
                      (d <= w) ? 1 : 0, 4 + d);
      end

    // R7: a retrigger reloads the window so a late partner still coincides
    clear_seq();
    seq[2] = 4'h1; seq[6] = 4'h1; seq[9] = 4'h2;
    play(mkcfg(15, 3, 1), np, fi);
    expect_pulses("R7 retrigger reload", np, fi, 1, 11);

    // R6: count climbing 1,2,3 within one window gives one pulse
    clear_seq();
    seq[2] = 4'h1; seq[3] = 4'h2; seq[4] = 4'h4;
    play(mkcfg(15, 5, 1), np, fi);
    expect_pulses("R6 no refire while over", np, fi, 1, 5);

    // R6: count drops below threshold then rises again -> second pulse
    clear_seq();
    seq[2] = 4'h3; seq[8] = 4'h3;
    play(mkcfg(15, 1, 1), np, fi);
    expect_pulses("R6 refire after drop", np, fi, 2, 4);

    // R5: threshold 0 ignores a long window
    clear_seq();
    seq[2] = 4'h1; seq[5] = 4'h2;
    play(mkcfg(15, 15, 0), np, fi);
    expect_pulses("R5 OR mode window ignored", np, fi, 2, 4);

    // R5/R2: threshold 0 with one channel masked
    clear_seq();
    seq[2] = 4'h1; seq[5] = 4'h2;
    play(mkcfg(1, 15, 0), np, fi);
    expect_pulses("R5 R2 OR mode masked", np, fi, 1, 4);

    // R8: level held high counts once
    clear_seq();
    for (int i = 2; i < 12; i++) seq[i] = 4'h1;
    play(mkcfg(15, 2, 0), np, fi);
    expect_pulses("R8 held input single event", np, fi, 1, 4);

    // R8: held high on one channel does not re-open its window
    clear_seq();
    for (int i = 2; i < 16; i++) seq[i] = 4'h1;
    seq[12] = 4'h3;
    play(mkcfg(15, 2, 1), np, fi);
    expect_pulses("R8 held input no window", np, fi, 0, 0);

    // R1: reset clears an open window
    @(negedge clk);
    cfg_word = mkcfg(15, 15, 1);
    self_trig = 4'h1;
    @(negedge clk);
    self_trig = 4'h0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    self_trig = 4'h2;
    @(negedge clk);
    self_trig = 4'h0;
    np = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (trig_out) np++;
    end
    check(np == 0, "R1 reset clears window", np, 0);

    summary();
  end
endmodule